// File: doc/BRIEF.md
# Serial Configuration Slave with Enable-Low Timeout

This block is the configuration port of a small transmitter. A host reaches it over a serial link of enable, clock and one data line. The block runs on a crystal-derived system clock. It passes the three inputs through two-flop synchronizers and finds their edges on the synchronized copies. A frame carries a direction bit, a register address and one data byte. Writes go into a small register file, and reads are shifted back to the host. The data line can be bidirectional (3-wire mode), or a dedicated output can carry the read data (4-wire mode). Bit 0 of register 0 selects between the two modes.

The level of the serial clock when enable rises picks the shifting edge for that whole transaction. A write to the command register can start or stop transmission. While transmission is active, each falling edge of enable samples the data line and drives that level onto the modulator data output, where it stays. The line can then be reused for configuration while the last bit keeps repeating. If enable stays low for long enough, the block aborts any frame, stops transmission, releases the dedicated output and requests power-down. The stored configuration is kept.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame is sent MSB first as 16 bits: a direction bit (1 = read, 0 = write), a 7-bit address, then 8 data bits. A write is committed on the 16th active edge. Addresses 0..NUM_REGS-1 hold storage. A write to any other non-command address is ignored, and a read of it returns 0x00.
- R2: If SCK is low when EN rises, data is shifted on rising SCK edges. If SCK is high when EN rises, data is shifted on falling SCK edges. The choice holds until EN goes low.
- R3: While EN is low, SCK and SDIO have no effect on the register file or the frame. A frame cut short by EN falling commits nothing. The next EN rise starts a fresh frame at bit 0.
- R4: 3-wire mode (register 0 bit 0 = 0): during a read, sdio_oe_o goes high after the 8th active edge. sdio_o then presents data bits 7..0, advancing one bit per active edge. sdio_oe_o drops on the cycle after EN's falling edge is seen.
- R5: 4-wire mode (register 0 bit 0 = 1): sdio_oe_o stays low. sdo_oe_o is raised at the next EN rise and stays high across EN low periods until a timeout. Read data appears on sdo_o with the R4 timing.
- R6: If the synchronized EN stays low for TIMEOUT_CYCLES consecutive cycles, the block does all of the following: it sets pwr_down_o, clears tx_active_o and mod_data_o, drops sdo_oe_o and aborts the frame. A shorter low period has no effect. pwr_down_o clears at the next EN rise.
- R7: A timeout leaves every register unchanged, including the 4-wire mode bit. The next EN rise in 4-wire mode re-enables sdo_oe_o.
- R8: The command address is CMD_ADDR (0x7F). Writing TX_START (0xA5) to it sets tx_active_o, and writing TX_STOP (0x5A) clears it. Any other value has no effect. A read of the command address returns 0x00.
- R9: While tx_active_o is high, each EN falling edge loads the synchronized SDIO level into mod_data_o, which holds it until the next such edge. While tx_active_o is low, EN edges leave mod_data_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Serial enable, high during a transaction |
| sck_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data line, input side |
| sdio_o | output | 1 | Serial data line, output value in 3-wire reads |
| sdio_oe_o | output | 1 | Drive enable for the serial data line |
| sdo_o | output | 1 | Dedicated read data output (4-wire) |
| sdo_oe_o | output | 1 | Drive enable for the dedicated output |
| mod_data_o | output | 1 | Bit held for the modulator |
| tx_active_o | output | 1 | Transmission running |
| pwr_down_o | output | 1 | Power-down request after an enable-low timeout |

## Verification
Each register is written and read back with both SCK idle levels. Mixed pairs, such as a write with SCK idle low followed by a read with SCK idle high, show that the shifting edge is latched per transaction and is not a fixed setting. Reads in 3-wire and 4-wire mode separate the two output paths. A frame aborted after 12 bits, followed by SCK and SDIO toggling while EN is low, shows that partial frames and idle activity leave the registers untouched. EN pulses with both SDIO levels, before and after the transmit command, separate the capture behaviour from ordinary frame ends. A low period just under the limit and one past it bracket the timeout, and the readback afterwards shows that the configuration survives.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pipe[0] <= '0;
    else         pipe[0] <= d_i;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) pipe[g] <= '0;
      else         pipe[g] <= pipe[g-1];
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_cfg_watchdog.sv
module spi_cfg_watchdog #(
  parameter int unsigned LIMIT = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic timeout_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  // saturates at LIMIT so the pulse fires once per low period
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt <= '0;
    else if (en_i)          cnt <= '0;
    else if (cnt != LIM_V)  cnt <= cnt + 1'b1;

  assign timeout_o = !en_i && (cnt == LAST_V);
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int    NUM_REGS = 4,
  parameter addr_t CMD_ADDR = 7'h7F,
  parameter data_t TX_START = 8'hA5,
  parameter data_t TX_STOP  = 8'h5A
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  addr_t addr_i,
  input  data_t wdata_i,
  output data_t rdata_o,
  output logic  wire4_o,
  input  logic  tx_clr_i,
  output logic  tx_active_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] rd_vec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    data_t q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                              q <= '0;
      else if (wr_i && addr_i == ADDR_W'(g))    q <= wdata_i;
    assign rd_vec[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = rd_vec[i];
  end

  assign wire4_o = rd_vec[0][0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        tx_active_o <= 1'b0;
    else if (tx_clr_i)  tx_active_o <= 1'b0;
    else if (wr_i && addr_i == CMD_ADDR) begin
      if (wdata_i == TX_START)     tx_active_o <= 1'b1;
      else if (wdata_i == TX_STOP) tx_active_o <= 1'b0;
    end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int          NUM_REGS       = 4,
  parameter int unsigned TIMEOUT_CYCLES = 65536,
  parameter addr_t       CMD_ADDR       = 7'h7F,
  parameter data_t       TX_START       = 8'hA5,
  parameter data_t       TX_STOP        = 8'h5A
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sck_i,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe_o,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic mod_data_o,
  output logic tx_active_o,
  output logic pwr_down_o
);
  localparam logic [CNT_W-1:0] CNT_IDLE  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_HLAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FLAST = CNT_W'(FRAME_BITS - 1);

  logic [2:0] syn;
  logic en_s, sck_s, sdio_s, en_q, sck_q;
  logic en_rise, en_fall, sck_edge, wd_timeout;

  spi_cfg_sync #(.W(3), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, sck_i, sdio_i}),
    .q_o   (syn)
  );
  assign {en_s, sck_s, sdio_s} = syn;

  spi_cfg_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_s),
    .timeout_o(wd_timeout)
  );

  logic [CNT_W-1:0]    cnt;
  logic [HDR_BITS-1:0] hdr;
  logic [DATA_W-2:0]   din;
  data_t               out_sr, rdata;
  addr_t               addr_mux;
  logic fall_mode, rd_drv, sdo_drv, wire4, wr_commit;

  assign en_rise  = en_s & ~en_q;
  assign en_fall  = ~en_s & en_q;
  // edge polarity latched at EN rise; idle counter value blocks stray edges
  assign sck_edge = en_s & en_q & (cnt != CNT_IDLE) &
                    (fall_mode ? (sck_q & ~sck_s) : (~sck_q & sck_s));

  // last header bit is still on the wire when the read address is needed
  assign addr_mux  = (cnt == CNT_HLAST) ? {hdr[ADDR_W-2:0], sdio_s} : hdr[ADDR_W-1:0];
  assign wr_commit = sck_edge && (cnt == CNT_FLAST) && !hdr[HDR_BITS-1];

  spi_cfg_regs #(
    .NUM_REGS(NUM_REGS),
    .CMD_ADDR(CMD_ADDR),
    .TX_START(TX_START),
    .TX_STOP (TX_STOP)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_commit),
    .addr_i     (addr_mux),
    .wdata_i    ({din, sdio_s}),
    .rdata_o    (rdata),
    .wire4_o    (wire4),
    .tx_clr_i   (wd_timeout),
    .tx_active_o(tx_active_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      sck_q      <= 1'b0;
      cnt        <= CNT_IDLE;
      hdr        <= '0;
      din        <= '0;
      out_sr     <= '0;
      fall_mode  <= 1'b0;
      rd_drv     <= 1'b0;
      sdo_drv    <= 1'b0;
      pwr_down_o <= 1'b0;
      mod_data_o <= 1'b0;
    end else begin
      en_q  <= en_s;
      sck_q <= sck_s;
      if (wd_timeout) begin
        cnt        <= CNT_IDLE;
        rd_drv     <= 1'b0;
        sdo_drv    <= 1'b0;
        pwr_down_o <= 1'b1;
        mod_data_o <= 1'b0;
      end else if (en_rise) begin
        cnt        <= '0;
        fall_mode  <= sck_s;
        pwr_down_o <= 1'b0;
        out_sr     <= '0;
        if (wire4) sdo_drv <= 1'b1;
      end else if (en_fall) begin
        cnt    <= CNT_IDLE;
        rd_drv <= 1'b0;
        if (tx_active_o) mod_data_o <= sdio_s;
      end else if (sck_edge) begin
        cnt <= cnt + 1'b1;
        if (cnt < CNT_HDR) begin
          hdr <= {hdr[HDR_BITS-2:0], sdio_s};
        end else begin
          din    <= {din[DATA_W-3:0], sdio_s};
          out_sr <= {out_sr[DATA_W-2:0], 1'b0};
        end
        if (cnt == CNT_HLAST && hdr[ADDR_W-1]) begin
          out_sr <= rdata;
          rd_drv <= 1'b1;
        end
      end
    end
  end

  assign sdio_o    = out_sr[DATA_W-1];
  assign sdo_o     = out_sr[DATA_W-1];
  assign sdio_oe_o = rd_drv & ~wire4;
  assign sdo_oe_o  = sdo_drv & wire4;
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_s,
  input logic en_fall,
  input logic wd_timeout,
  input logic wire4,
  input logic sdio_oe_o,
  input logic sdo_oe_o,
  input logic mod_data_o,
  input logic tx_active_o,
  input logic pwr_down_o
);
  // R6
  timeout_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_timeout |=> (pwr_down_o && !tx_active_o && !sdo_oe_o && !mod_data_o));

  // R6
  pwr_down_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_down_o) |-> $past(wd_timeout));

  // R4
  sdio_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fall |=> !sdio_oe_o);

  // R5
  wire4_no_sdio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wire4 |-> !sdio_oe_o);

  // R9
  mod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mod_data_o) && !$past(wd_timeout)) |-> $past(en_fall && tx_active_o));

  // R8
  tx_start_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_o) |-> $past(en_s));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_s       (en_s),
  .en_fall    (en_fall),
  .wd_timeout (wd_timeout),
  .wire4      (wire4),
  .sdio_oe_o  (sdio_oe_o),
  .sdo_oe_o   (sdo_oe_o),
  .mod_data_o (mod_data_o),
  .tx_active_o(tx_active_o),
  .pwr_down_o (pwr_down_o)
);

// File: tb/spi_cfg_slave_tb_top.sv
module spi_cfg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int TIMEOUT    = 65536;

  logic clk, rst_n, en, sck, drv_sdio, sdio_line;
  logic sdio_o, sdio_oe_o, sdo_o, sdo_oe_o, mod_data_o, tx_active_o, pwr_down_o;

  assign sdio_line = sdio_oe_o ? sdio_o : drv_sdio;

  spi_cfg_slave #(.TIMEOUT_CYCLES(TIMEOUT)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .sck_i      (sck),
    .sdio_i     (sdio_line),
    .sdio_o     (sdio_o),
    .sdio_oe_o  (sdio_oe_o),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .mod_data_o (mod_data_o),
    .tx_active_o(tx_active_o),
    .pwr_down_o (pwr_down_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] cap_byte;
  logic       last_sdio_oe, last_sdo_oe;
  event       cap_ev;

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one transaction; first SCK toggle after EN rise is the active edge in both modes
  task automatic xfer(bit rd, logic [6:0] addr, logic [7:0] wd, bit cpol, bit sdo_path, int nbits);
    logic [15:0] fr;
    logic [7:0]  cap;
    fr  = {rd, addr, wd};
    cap = '0;
    sck = cpol;
    wclk(4);
    en = 1'b1;
    wclk(6);
    for (int i = 0; i < nbits; i++) begin
      if (!(rd && i >= 8)) drv_sdio = fr[15-i];
      wclk(HALF_SCK);
      if (rd && i >= 8) cap = {cap[6:0], sdo_path ? sdo_o : sdio_line};
      sck = ~cpol;
      wclk(HALF_SCK);
      sck = cpol;
    end
    wclk(HALF_SCK);
    last_sdio_oe = sdio_oe_o;
    last_sdo_oe  = sdo_oe_o;
    en = 1'b0;
    wclk(6);
    if (rd && nbits == 16) begin
      cap_byte = cap;
      -> cap_ev;
    end
  endtask

  task automatic wr(logic [6:0] addr, logic [7:0] d, bit cpol);
    xfer(1'b0, addr, d, cpol, 1'b0, 16);
  endtask

  task automatic rd_exp(logic [6:0] addr, logic [7:0] exp, bit cpol, bit sdo_path, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(1'b1, addr, 8'h00, cpol, sdo_path, 16);
  endtask

  task automatic en_pulse(bit d);
    drv_sdio = d;
    wclk(4);
    en = 1'b1;
    wclk(6);
    en = 1'b0;
    wclk(6);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(cap_ev);
      if (exp_q.size() == 0) begin
        check("R1", "unexpected read", {24'h0, cap_byte}, 32'hFFFF_FFFF);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "read byte", {24'h0, cap_byte}, {24'h0, e});
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; sck = 1'b0; drv_sdio = 1'b0;
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    check("R6", "pwr_down after reset", {31'h0, pwr_down_o}, 0);
    check("R8", "tx_active after reset", {31'h0, tx_active_o}, 0);
    check("R9", "mod_data after reset", {31'h0, mod_data_o}, 0);
    check("R4", "sdio_oe after reset", {31'h0, sdio_oe_o}, 0);
    check("R5", "sdo_oe after reset", {31'h0, sdo_oe_o}, 0);

    // R1 basic write/read, rising edges
    wr(7'd1, 8'h3C, 1'b0);
    rd_exp(7'd1, 8'h3C, 1'b0, 1'b0, "R1");
    check("R4", "sdio_oe during read", {31'h0, last_sdio_oe}, 1);
    check("R4", "sdo_oe during 3-wire read", {31'h0, last_sdo_oe}, 0);
    check("R4", "sdio_oe after EN low", {31'h0, sdio_oe_o}, 0);

    // R2 falling-edge transactions and mixed pairs
    wr(7'd2, 8'hC3, 1'b1);
    rd_exp(7'd2, 8'hC3, 1'b1, 1'b0, "R2");
    rd_exp(7'd2, 8'hC3, 1'b0, 1'b0, "R2");
    rd_exp(7'd1, 8'h3C, 1'b1, 1'b0, "R2");
    check("R9", "mod_data idle without tx", {31'h0, mod_data_o}, 0);

    // R1 unmapped address
    wr(7'd5, 8'h77, 1'b0);
    rd_exp(7'd5, 8'h00, 1'b0, 1'b0, "R1");
    rd_exp(7'd1, 8'h3C, 1'b0, 1'b0, "R1");

    // R3 aborted frame and idle toggling
    wr(7'd3, 8'h11, 1'b0);
    xfer(1'b0, 7'd3, 8'hEE, 1'b0, 1'b0, 12);
    for (int i = 0; i < 6; i++) begin
      sck = ~sck; drv_sdio = ~drv_sdio;
      wclk(HALF_SCK);
    end
    sck = 1'b0;
    rd_exp(7'd3, 8'h11, 1'b0, 1'b0, "R3");
    rd_exp(7'd1, 8'h3C, 1'b1, 1'b0, "R3");

    // R8 command register
    wr(7'h7F, 8'h33, 1'b0);
    check("R8", "tx after other value", {31'h0, tx_active_o}, 0);
    rd_exp(7'h7F, 8'h00, 1'b0, 1'b0, "R8");
    wr(7'h7F, 8'hA5, 1'b0);
    check("R8", "tx after start", {31'h0, tx_active_o}, 1);
    check("R9", "mod after start frame end", {31'h0, mod_data_o}, 1);

    // R9 EN falling edges capture SDIO
    en_pulse(1'b0);
    check("R9", "mod capture 0", {31'h0, mod_data_o}, 0);
    drv_sdio = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sck = ~sck;
      wclk(HALF_SCK);
    end
    check("R9", "mod held without EN fall", {31'h0, mod_data_o}, 0);
    en_pulse(1'b1);
    check("R9", "mod capture 1", {31'h0, mod_data_o}, 1);
    sck = 1'b0;
    wr(7'd3, 8'h7E, 1'b0);
    check("R9", "mod after config frame", {31'h0, mod_data_o}, 0);
    check("R8", "tx kept during config", {31'h0, tx_active_o}, 1);
    rd_exp(7'd3, 8'h7E, 1'b0, 1'b0, "R9");

    // R6 short low period
    wclk(1000);
    check("R6", "pwr_down after short low", {31'h0, pwr_down_o}, 0);
    check("R6", "tx after short low", {31'h0, tx_active_o}, 1);

    // R5 4-wire mode
    wr(7'd0, 8'h01, 1'b0);
    check("R5", "sdo_oe before next EN rise", {31'h0, sdo_oe_o}, 0);
    rd_exp(7'd1, 8'h3C, 1'b0, 1'b1, "R5");
    check("R5", "sdio_oe in 4-wire read", {31'h0, last_sdio_oe}, 0);
    check("R5", "sdo_oe in 4-wire read", {31'h0, last_sdo_oe}, 1);
    check("R5", "sdo_oe held after EN low", {31'h0, sdo_oe_o}, 1);
    rd_exp(7'd2, 8'hC3, 1'b1, 1'b1, "R5");

    // R8 stop then restart
    wr(7'h7F, 8'h5A, 1'b0);
    check("R8", "tx after stop", {31'h0, tx_active_o}, 0);
    wr(7'h7F, 8'hA5, 1'b0);
    check("R8", "tx after restart", {31'h0, tx_active_o}, 1);
    check("R9", "mod before timeout", {31'h0, mod_data_o}, 1);

    // R6 timeout boundary
    wclk(TIMEOUT - 1000);
    check("R6", "pwr_down just under limit", {31'h0, pwr_down_o}, 0);
    wclk(1020);
    check("R6", "pwr_down after timeout", {31'h0, pwr_down_o}, 1);
    check("R6", "tx cleared by timeout", {31'h0, tx_active_o}, 0);
    check("R6", "mod cleared by timeout", {31'h0, mod_data_o}, 0);
    check("R6", "sdo released by timeout", {31'h0, sdo_oe_o}, 0);

    // R7 config survives, R6 wake on EN rise
    en = 1'b1;
    wclk(6);
    check("R6", "pwr_down after EN rise", {31'h0, pwr_down_o}, 0);
    check("R7", "sdo_oe back in 4-wire", {31'h0, sdo_oe_o}, 1);
    en = 1'b0;
    wclk(6);
    rd_exp(7'd0, 8'h01, 1'b0, 1'b1, "R7");
    rd_exp(7'd2, 8'hC3, 1'b0, 1'b1, "R7");
    rd_exp(7'd3, 8'h7E, 1'b1, 1'b1, "R7");

    wclk(4);
    check("R1", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule